// File: doc/BRIEF.md
# Serial Receive FIFO with Programmable Fill Trigger

This block buffers received serial bytes in a 16-entry queue between the line receiver and the register file. Bytes arrive on a valid/ready stream. The oldest byte is removed by a single-cycle pop strobe that the register decoder raises when software reads the receive data register. The block keeps a live entry count. It raises a fill flag, and optionally an interrupt, once the count reaches a threshold. Software picks that threshold from four fixed levels: 1, 4, 8 and 14 entries.

The inbound stream follows these back-pressure rules. `in_ready` is high only while reception is enabled and the queue holds fewer than 16 bytes. A byte counts as delivered only in a cycle with both `in_valid` and `in_ready` high. The line receiver has no storage of its own, so a byte offered while `in_ready` is low is lost. The pop side, the trigger select, the flush request, the enables and the flag-clear input are plain level or strobe signals with no handshake.

The fill flag is re-evaluated only on traffic. A push can set it, a pop that leaves fewer entries than the threshold clears it, and a flush or the external clear removes it. Changing the trigger select alone never changes the flag. The interrupt follows the push that sets the flag. It stays up through pops and drops only on the external clear or when interrupt enable goes low.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, `count` is 0, `rx_full` and `irq` are 0, and `pop_data` reads 0xFF.
- R2: `in_ready` equals `rx_en` AND (`count` < 16). With `rx_en` low, an offered byte is not stored and `count` does not change.
- R3: At `count` = 16, `in_ready` is low, and a byte offered then is dropped without changing the count or the stored bytes.
- R4: `pop_data` shows the oldest stored byte. A `pop` with `count` > 0 removes that byte and lowers `count` by one. Order is preserved across pointer wrap.
- R5: A `pop` with `count` = 0 changes nothing, and `pop_data` reads 0xFF.
- R6: An accepted push and a nonempty pop in the same cycle leave `count` unchanged and keep first-in first-out order.
- R7: `trig_sel` selects the threshold: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14.
- R8: `rx_full` sets on the edge after an accepted push leaves `count` at or above the threshold. It clears only when a pop leaves `count` below the threshold. A change of `trig_sel` alone leaves it as it is.
- R9: `flush` empties the queue (`count` 0, pointers to 0) and clears `rx_full`, taking priority over a push or pop in the same cycle. It does not change `irq`.
- R10: When `rxie` is 1, the push that sets `rx_full` also sets `irq`. Pops do not clear `irq`. `rxie` low forces `irq` to 0 on the next edge.
- R11: `flag_clr` clears `rx_full` and `irq`. If a threshold-reaching push happens in the same cycle, the flag and the interrupt are set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received byte is offered |
| in_ready | output | 1 | Queue can take a byte this cycle |
| in_data | input | 8 | Received byte |
| pop | input | 1 | Remove the oldest byte (register read strobe) |
| pop_data | output | 8 | Oldest byte, 0xFF when empty |
| trig_sel | input | 2 | Fill threshold select |
| flush | input | 1 | Empty the queue and clear the fill flag |
| rx_en | input | 1 | Reception enable |
| rxie | input | 1 | Receive interrupt enable |
| flag_clr | input | 1 | Software clear of fill flag and interrupt |
| count | output | 5 | Number of stored bytes |
| rx_full | output | 1 | Count reached the threshold |
| irq | output | 1 | Receive interrupt |

## Verification
Push and pop can land in the same cycle. The vector walk provokes this with a push and a pop together while the queue sits exactly at the threshold, and it judges the result by an unchanged count, a held flag and the next byte in order on `pop_data`. A threshold-reaching push is also driven in the same cycle as `flag_clr`, and the flag and interrupt must come out set. Flush is driven together with queue traffic through the flush-priority property, and in the bench by its effect on `count` and `irq`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Threshold for each trigger select code; the mapping is not linear.
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          flush,
  output logic [DW-1:0] head_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, wptr_inc, rptr_inc;

  generate
    if ((1 << PW) == DEPTH) begin : g_pow2
      assign wptr_inc = wptr + 1'b1;
      assign rptr_inc = rptr + 1'b1;
    end else begin : g_wrap
      assign wptr_inc = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_inc = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr) wptr <= wptr_inc;
      if (rd) rptr <= rptr_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !flush) mem[wptr] <= wdata;
  end

  assign head_data = mem[rptr];
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [1:0]    trig_sel,
  input  logic          rxie,
  input  logic          flag_clr,
  output logic [CW-1:0] count,
  output logic          rx_full,
  output logic          irq
);
  import rxf_pkg::*;

  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] thr;
  logic          set_ev, drop_ev;

  assign thr = CW'(trig_level(trig_sel));

  always_comb begin
    cnt_nxt = count;
    if (push && !pop)      cnt_nxt = count + 1'b1;
    else if (pop && !push) cnt_nxt = count - 1'b1;
  end

  assign set_ev  = push && (cnt_nxt >= thr);
  assign drop_ev = pop  && (cnt_nxt <  thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      rx_full <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (flush) begin
        count   <= '0;
        rx_full <= 1'b0;
      end else begin
        count <= cnt_nxt;
        if (set_ev)                   rx_full <= 1'b1;
        else if (drop_ev || flag_clr) rx_full <= 1'b0;
      end

      if (!rxie)                   irq <= 1'b0;
      else if (set_ev && !flush)   irq <= 1'b1;
      else if (flag_clr)           irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  input  logic [1:0]    trig_sel,
  input  logic          flush,
  input  logic          rx_en,
  input  logic          rxie,
  input  logic          flag_clr,
  output logic [CW-1:0] count,
  output logic          rx_full,
  output logic          irq
);
  logic          do_push, do_pop, empty;
  logic [DW-1:0] head_data;

  assign empty    = (count == '0);
  assign in_ready = rx_en && (count < CW'(DEPTH));
  assign do_push  = in_valid && in_ready && !flush;
  assign do_pop   = pop && !empty && !flush;
  assign pop_data = empty ? {DW{1'b1}} : head_data;

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (do_push),
    .wdata    (in_data),
    .rd       (do_pop),
    .flush    (flush),
    .head_data(head_data)
  );

  rxf_level #(.DEPTH(DEPTH)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (do_push),
    .pop     (do_pop),
    .flush   (flush),
    .trig_sel(trig_sel),
    .rxie    (rxie),
    .flag_clr(flag_clr),
    .count   (count),
    .rx_full (rx_full),
    .irq     (irq)
  );
endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          pop,
  input logic [DW-1:0] pop_data,
  input logic          flush,
  input logic          rx_en,
  input logic          rxie,
  input logic [CW-1:0] count,
  input logic          rx_full,
  input logic          irq
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !in_ready);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !in_ready);

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (pop_data == {DW{1'b1}}));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop && !(in_valid && in_ready) && !flush) |=> (count == '0));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !rx_full));

  assert_push_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && pop && count != '0 && !flush) |=> $stable(count));

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rxie |=> !irq);

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> rx_full);
endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .pop(pop), .pop_data(pop_data), .flush(flush), .rx_en(rx_en),
  .rxie(rxie), .count(count), .rx_full(rx_full), .irq(irq)
);

// File: tb/rx_trig_fifo_tb.sv
module rx_trig_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // vector: push, data[7:0], pop, exp_count[4:0], exp_full, exp_rd[7:0]
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 5'd1, 1'b0, 8'h11},
    {1'b1, 8'h22, 1'b0, 5'd2, 1'b0, 8'h11},
    {1'b1, 8'h33, 1'b0, 5'd3, 1'b0, 8'h11},
    {1'b1, 8'h44, 1'b0, 5'd4, 1'b1, 8'h11},
    {1'b1, 8'h55, 1'b1, 5'd4, 1'b1, 8'h22},
    {1'b0, 8'h00, 1'b1, 5'd3, 1'b0, 8'h33},
    {1'b1, 8'h66, 1'b0, 5'd4, 1'b1, 8'h33},
    {1'b0, 8'h00, 1'b1, 5'd3, 1'b0, 8'h44},
    {1'b0, 8'h00, 1'b1, 5'd2, 1'b0, 8'h55},
    {1'b0, 8'h00, 1'b1, 5'd1, 1'b0, 8'h66},
    {1'b0, 8'h00, 1'b1, 5'd0, 1'b0, 8'hFF},
    {1'b0, 8'h00, 1'b1, 5'd0, 1'b0, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, pop = 1'b0, flush = 1'b0, flag_clr = 1'b0;
  logic rx_en = 1'b1, rxie = 1'b1;
  logic [7:0] in_data = '0;
  logic [1:0] trig_sel = 2'd0;
  logic in_ready, rx_full, irq;
  logic [7:0] pop_data;
  logic [4:0] count;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_trig_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pop(pop), .pop_data(pop_data), .trig_sel(trig_sel),
    .flush(flush), .rx_en(rx_en), .rxie(rxie), .flag_clr(flag_clr),
    .count(count), .rx_full(rx_full), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive for one edge, return at the following falling edge
  task automatic cyc(input logic v, input logic [7:0] d, input logic p);
    in_valid = v; in_data = d; pop = p;
    @(posedge clk); @(negedge clk);
    in_valid = 0; pop = 0; flush = 0; flag_clr = 0;
  endtask

  task automatic do_flush();
    flush = 1; cyc(0, 8'h00, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pop_data", pop_data, 8'hFF);
    rst_n = 1;
    @(negedge clk);

    // vector walk at threshold 4 (R4 R5 R6 R8)
    trig_sel = 2'd1;
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][23], VEC[i][22:15], VEC[i][14]);
      chk("R4/R6 count", count, VEC[i][13:9]);
      chk("R8 rx_full", rx_full, VEC[i][8]);
      chk("R4/R5 pop_data", pop_data, VEC[i][7:0]);
    end
    // R10 irq set in the walk, not cleared by pops
    chk("R10 irq held after pops", irq, 1);
    flag_clr = 1; cyc(0, 8'h00, 0);
    chk("R11 flag_clr drops irq", irq, 0);

    // R7 trigger map
    for (int s = 0; s < 4; s++) begin
      int first;
      do_flush();
      trig_sel = 2'(s);
      first = 0;
      for (int k = 1; k <= 16; k++) begin
        cyc(1, 8'(k), 0);
        if (rx_full && first == 0) first = k;
      end
      chk("R7 threshold", first, (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14);
    end

    // R3 full queue, R4 wrap order
    do_flush();
    trig_sel = 2'd0;
    for (int k = 0; k < 3; k++) cyc(1, 8'hEE, 0);
    for (int k = 0; k < 3; k++) cyc(0, 8'h00, 1);
    for (int k = 0; k < 16; k++) cyc(1, 8'h80 + 8'(k), 0);
    chk("R3 count at 16", count, 16);
    chk("R3 in_ready low", in_ready, 0);
    cyc(1, 8'h55, 0);
    chk("R3 dropped byte count", count, 16);
    for (int k = 0; k < 16; k++) begin
      chk("R4 wrap order", pop_data, 8'h80 + k);
      cyc(0, 8'h00, 1);
    end
    chk("R5 empty after drain", count, 0);

    // R2 reception disabled
    rx_en = 0; @(negedge clk);
    chk("R2 in_ready gated", in_ready, 0);
    cyc(1, 8'h12, 0);
    chk("R2 no store", count, 0);
    rx_en = 1;

    // R8 trig change alone keeps flag; R9 flush keeps irq
    trig_sel = 2'd1;
    for (int k = 0; k < 5; k++) cyc(1, 8'h30 + 8'(k), 0);
    chk("R8 full at 5/4", rx_full, 1);
    trig_sel = 2'd3; cyc(0, 8'h00, 0);
    chk("R8 trig change keeps flag", rx_full, 1);
    flush = 1; cyc(1, 8'h77, 1);
    chk("R9 flush count", count, 0);
    chk("R9 flush flag", rx_full, 0);
    chk("R9 flush keeps irq", irq, 1);
    chk("R9 flush pop_data", pop_data, 8'hFF);

    // R10 rxie low clears irq
    rxie = 0; cyc(0, 8'h00, 0);
    chk("R10 rxie low", irq, 0);
    rxie = 1;

    // R11 clear vs same-cycle threshold push
    trig_sel = 2'd0;
    flag_clr = 1; cyc(1, 8'h9A, 0);
    chk("R11 push wins flag", rx_full, 1);
    chk("R11 push wins irq", irq, 1);
    flag_clr = 1; cyc(0, 8'h00, 0);
    chk("R11 clear flag", rx_full, 0);
    chk("R11 clear keeps data", pop_data, 8'h9A);

    finish_run();
  end
endmodule